// File: doc/BRIEF.md
# Synchronous Serial Frame Port

This block is a clocked serial port in the SPI style. Words written into its transmit queue are sent out one frame at a time, most significant bit first, on a data output line. A serial clock and an active-low frame select are generated alongside the data. The receive line is sampled during each frame, and the received bits are collected into a word that goes into a receive queue. Frames of 4 to 16 bits are supported. A polarity input sets the clock's resting level. A phase input picks whether data is captured on the first or the second clock edge of each bit.

A frame starts by itself when the port is enabled and the transmit queue holds data. While the queue stays non-empty, frames follow one another, with frame select raised for one serial clock period between them. The serial clock comes from the system clock through an even prescaler. Frame length, polarity, phase and prescaler are taken while the port is idle, and all frames of one burst use those settings. A mode input only decides whether the clock output driver is enabled (master) or released (slave). The frame engine itself always generates the clock.

Top module: `serial_frame_port`

## Requirements
- R1: While idle, frame select is high, the data output is low with its output enable low, busy is low, and the serial clock rests at the level of the polarity input (0 gives a low clock).
- R2: The clock output enable `sclk_oe` is 1 when `master_mode` is 1 and 0 when `master_mode` is 0.
- R3: A frame starts only when `en` is 1 and the transmit queue is not empty. Frame select falls on the first clock edge that sees both conditions. With `en` at 0, queued data waits and frame select stays high.
- R4: The frame length is `frame_bits`, with values below 4 treated as 4 and values above 16 treated as 16. Each frame has exactly that many capture edges.
- R5: The data output presents the low frame-length bits of the transmit word, most significant first. Each bit is stable around its capture edge.
- R6: With `cpha` at 0, capture happens on the first clock edge of each bit, which leaves the rest level. With `cpha` at 1, capture happens on the second clock edge, which returns to the rest level. Data changes only on bit boundaries.
- R7: Each received frame is placed in the low bits of a 16-bit word, with the upper bits zero, and is pushed into the receive queue.
- R8: One bit lasts `prescale` system clocks, where `prescale` is even and at least 2. Frame select stays low for `prescale*(n+1)` clocks per frame of n bits.
- R9: When more transmit data is waiting, the next frame follows at once, and frame select is high for exactly `prescale` clocks between the two frames.
- R10: A frame that ends while the receive queue is full is dropped, and `overrun` is set and stays set until reset. Earlier queue contents are kept.
- R11: `busy` rises with frame select falling and stays high across gaps between frames. It falls once the last frame's gap is over and the lines are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Port enable |
| master_mode | input | 1 | 1 drives the clock pad, 0 releases it |
| cpol | input | 1 | Clock rest level |
| cpha | input | 1 | 0 captures on first edge, 1 on second |
| frame_bits | input | 5 | Bits per frame (clamped to 4..16) |
| prescale | input | PRE_W | System clocks per bit (even, at least 2) |
| tx_push | input | 1 | Write a word into the transmit queue |
| tx_wdata | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head word of the receive queue |
| rx_rdata | output | 16 | Head word of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| overrun | output | 1 | Sticky: a received frame was dropped |
| busy | output | 1 | A burst of frames is in progress |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock output enable |
| fss_n | output | 1 | Active-low frame select |
| txd | output | 1 | Serial data out |
| txd_oe | output | 1 | Serial data output enable |
| rxd | input | 1 | Serial data in |

## Verification
Frame select is due one system clock after the clock edge that sees the port enabled with data queued. It then stays low for `prescale*(n+1)` clocks, and the gap between frames lasts `prescale` clocks. The bench samples every output on the falling system clock edge. It counts low and high runs of frame select in whole cycles and compares those counts with these formulas, and it checks the first low sample on the exact cycle. It rebuilds each transmitted word from the data line at the capture edges implied by polarity and phase. Received words are read only after `busy` falls, which is always later than the receive push at the last capture edge.

// File: rtl/ssp_pkg.sv
// Package: shared constants and types for the serial frame port.
// Assumes a fixed 16-bit queue word; frames use its low bits.
package ssp_pkg;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned MIN_BITS = 4;
    localparam int unsigned NB_W     = 5;

    typedef logic [WORD_W-1:0] word_t;

    // Frame sequencer states: idle, half-bit lead-in, data bits,
    // half-bit tail, one-bit inter-frame gap.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_BIT,
        ST_HOLD,
        ST_GAP
    } seq_t;
endpackage

// File: rtl/ssp_fifo.sv
// Module: ssp_fifo
// Show-ahead synchronous queue. A push when full and a pop when empty
// are ignored. Assumes DEPTH >= 2.
module ssp_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign rdata   = mem[rp];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // Occupancy never exceeds capacity (guards the R10 drop path).
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);

    // A push into a full queue leaves the count unchanged (R10).
    p_full_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/ssp_sclk_div.sv
// Module: ssp_sclk_div
// Half-bit timer. While run is high it pulses tick once every `half`
// system clocks; while run is low it stays preloaded so that the first
// half after run rises is full length. Assumes half >= 1.
module ssp_sclk_div #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-2:0] half,
    output logic             tick
);
    logic [PRE_W-2:0] cnt;

    assign tick = run && (cnt == '0);

    // Count down one half-bit, reload on expiry or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (!run || cnt == '0)  cnt <= half - 1'b1;
        else                         cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/ssp_frame_engine.sv
// Module: ssp_frame_engine
// Frame sequencer: pulls words from the transmit queue, shifts them out
// MSB first, samples rxd at the capture edge chosen by phase, and pushes
// right-justified words to the receive queue. Settings are sampled while
// idle and hold for a whole burst. Assumes an even prescale >= 2.
module ssp_frame_engine
    import ssp_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [NB_W-1:0]  frame_bits,
    input  logic [PRE_W-1:0] prescale,
    input  logic             tx_empty,
    input  word_t            tx_data,
    output logic             tx_pop,
    input  logic             rx_full,
    output logic             rx_push,
    output word_t            rx_data,
    input  logic             rxd,
    output logic             sclk_o,
    output logic             fss_n,
    output logic             txd,
    output logic             txd_oe,
    output logic             busy,
    output logic             overrun
);
    localparam logic [NB_W-1:0] NB_MIN = NB_W'(MIN_BITS);
    localparam logic [NB_W-1:0] NB_MAX = NB_W'(WORD_W);

    seq_t             state;
    logic             h;
    logic [NB_W-1:0]  bidx;
    word_t            tsh, rsh;
    logic             cfg_cpol, cfg_cpha;
    logic [NB_W-1:0]  cfg_nb;
    logic [PRE_W-2:0] cfg_half;
    logic             ovr;

    logic [NB_W-1:0]  live_nb, use_nb;
    logic [PRE_W-2:0] live_half, use_half;
    logic             tick, start_ok, start_now, active, last_bit, cap;

    // Clamp requested frame length and derive the half-bit length.
    always_comb begin
        if (frame_bits < NB_MIN)      live_nb = NB_MIN;
        else if (frame_bits > NB_MAX) live_nb = NB_MAX;
        else                          live_nb = frame_bits;
        if (prescale[PRE_W-1:1] == '0) live_half = (PRE_W-1)'(1);
        else                           live_half = prescale[PRE_W-1:1];
    end

    assign use_nb   = (state == ST_IDLE) ? live_nb   : cfg_nb;
    assign use_half = (state == ST_IDLE) ? live_half : cfg_half;

    ssp_sclk_div #(.PRE_W(PRE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .half  (use_half),
        .tick  (tick)
    );

    assign start_ok  = en && !tx_empty;
    assign start_now = start_ok &&
                       ((state == ST_IDLE) || (tick && state == ST_GAP && h));
    assign tx_pop    = start_now;
    assign last_bit  = (bidx == cfg_nb - 1'b1);
    assign cap       = tick && (state == ST_BIT) && !h;
    assign rx_data   = {rsh[WORD_W-2:0], rxd};
    assign rx_push   = cap && last_bit && !rx_full;

    assign active  = (state == ST_SETUP) || (state == ST_BIT) || (state == ST_HOLD);
    assign fss_n   = !active;
    assign txd     = active && tsh[WORD_W-1];
    assign txd_oe  = active;
    assign sclk_o  = cfg_cpol ^ ((state == ST_BIT) && (h ^ cfg_cpha));
    assign busy    = (state != ST_IDLE);
    assign overrun = ovr;

    // Sequencer: settings capture, frame load, bit stepping, gap, drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            h        <= 1'b0;
            bidx     <= '0;
            tsh      <= '0;
            rsh      <= '0;
            cfg_cpol <= 1'b0;
            cfg_cpha <= 1'b0;
            cfg_nb   <= NB_MIN;
            cfg_half <= (PRE_W-1)'(1);
            ovr      <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                cfg_cpol <= cpol;
                cfg_cpha <= cpha;
                cfg_nb   <= live_nb;
                cfg_half <= live_half;
            end
            if (start_now) begin
                state <= ST_SETUP;
                tsh   <= tx_data << (NB_MAX - use_nb);
                rsh   <= '0;
            end else if (tick) begin
                case (state)
                    ST_SETUP: begin
                        state <= ST_BIT;
                        h     <= 1'b0;
                        bidx  <= '0;
                    end
                    ST_BIT: begin
                        if (!h) begin
                            h   <= 1'b1;
                            rsh <= {rsh[WORD_W-2:0], rxd};
                        end else if (last_bit) begin
                            state <= ST_HOLD;
                        end else begin
                            h    <= 1'b0;
                            bidx <= bidx + 1'b1;
                            tsh  <= tsh << 1;
                        end
                    end
                    ST_HOLD: begin
                        state <= ST_GAP;
                        h     <= 1'b0;
                    end
                    ST_GAP: begin
                        if (!h) h <= 1'b1;
                        else    state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
            if (cap && last_bit && rx_full) ovr <= 1'b1;
        end
    end

    // Idle line levels (R1).
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (fss_n && !txd && !txd_oe));

    // Frame select falls only with the port enabled and data queued (R3).
    p_start_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fss_n) |-> $past(en && !tx_empty));

    // Data line holds through the second half of each bit (R6).
    p_txd_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT && h && $past(state == ST_BIT && h)) |-> $stable(txd));

    // Overrun flag is sticky (R10).
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // Busy is high whenever frame select is low (R11).
    p_busy_covers_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fss_n |-> busy);
endmodule

// File: rtl/serial_frame_port.sv
// Module: serial_frame_port
// Top: transmit queue, receive queue and frame engine; drives the clock
// pad enable from the mode input. Assumes even prescale >= 2.
module serial_frame_port
    import ssp_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 4,
    parameter int PRE_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             master_mode,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [4:0]       frame_bits,
    input  logic [PRE_W-1:0] prescale,
    input  logic             tx_push,
    input  logic [15:0]      tx_wdata,
    output logic             tx_full,
    input  logic             rx_pop,
    output logic [15:0]      rx_rdata,
    output logic             rx_empty,
    output logic             overrun,
    output logic             busy,
    output logic             sclk_o,
    output logic             sclk_oe,
    output logic             fss_n,
    output logic             txd,
    output logic             txd_oe,
    input  logic             rxd
);
    word_t tx_head, rx_word;
    logic  tx_empty, tx_pop, rx_full, rx_push;

    ssp_fifo #(.DEPTH(TX_DEPTH), .W(WORD_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.DEPTH(RX_DEPTH), .W(WORD_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_rdata), .full(rx_full), .empty(rx_empty)
    );

    ssp_frame_engine #(.PRE_W(PRE_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha),
        .frame_bits(frame_bits), .prescale(prescale),
        .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_word),
        .rxd(rxd), .sclk_o(sclk_o), .fss_n(fss_n), .txd(txd),
        .txd_oe(txd_oe), .busy(busy), .overrun(overrun)
    );

    // Clock pad driven in master mode, released in slave mode.
    assign sclk_oe = master_mode;
endmodule

// File: tb/serial_frame_port_tb.sv
module serial_frame_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, master_mode = 1'b1, cpol = 1'b0, cpha = 1'b0;
    logic [4:0] frame_bits = 5'd8;
    logic [7:0] prescale = 8'd2;
    logic tx_push = 1'b0, rx_pop = 1'b0, rx_inv = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic tx_full, rx_empty, overrun, busy, sclk_o, sclk_oe, fss_n, txd, txd_oe, rxd;
    logic [15:0] rx_rdata;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;
    assign rxd = rx_inv ? ~txd : txd;

    serial_frame_port u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .master_mode(master_mode),
        .cpol(cpol), .cpha(cpha), .frame_bits(frame_bits), .prescale(prescale),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_empty(rx_empty),
        .overrun(overrun), .busy(busy), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .fss_n(fss_n), .txd(txd), .txd_oe(txd_oe), .rxd(rxd)
    );

    // Line monitor on the falling system edge: frame word, edges, run lengths.
    logic fss_prev = 1'b1, sclk_prev = 1'b0;
    logic [15:0] mon = '0, last_word = '0;
    int edges = 0, last_edges = 0, low_run = 0, hi_run = 0;
    int last_low = 0, last_gap = 0, frames = 0;
    always @(negedge clk) begin
        fss_prev  <= fss_n;
        sclk_prev <= sclk_o;
        if (!fss_n) low_run <= low_run + 1; else low_run <= 0;
        if (fss_n && busy) hi_run <= hi_run + 1; else hi_run <= 0;
        if (!fss_n && fss_prev) begin
            mon <= '0;
            edges <= 0;
            if (hi_run != 0) last_gap <= hi_run;
        end else if (!fss_n && sclk_o != sclk_prev && sclk_o == (cpol == cpha)) begin
            mon <= {mon[14:0], txd};
            edges <= edges + 1;
        end
        if (fss_n && !fss_prev) begin
            last_word  <= mon;
            last_edges <= edges;
            last_low   <= low_run;
            frames     <= frames + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        @(negedge clk);
        tx_push = 1'b1;
        tx_wdata = w;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_rx(output logic [15:0] w);
        w = rx_rdata;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_done();
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic int clampn(input int n);
        return (n < 4) ? 4 : (n > 16) ? 16 : n;
    endfunction

    // Reset levels and pad enable by mode.
    task automatic t_reset();
        chk("R1 fss_n idle", fss_n, 1);
        chk("R1 txd idle", txd, 0);
        chk("R1 txd_oe idle", txd_oe, 0);
        chk("R1 busy idle", busy, 0);
        chk("R1 sclk idle cpol0", sclk_o, 0);
        chk("R7 rx_empty", rx_empty, 1);
        chk("R2 sclk_oe master", sclk_oe, 1);
        master_mode = 1'b0;
        @(negedge clk);
        chk("R2 sclk_oe slave", sclk_oe, 0);
        master_mode = 1'b1;
    endtask

    // Enable gating and first-cycle start timing.
    task automatic t_enable_gate();
        logic [15:0] w;
        frame_bits = 5'd8; prescale = 8'd4;
        push(16'hA5C3);
        repeat (20) @(negedge clk);
        chk("R3 held while disabled fss_n", fss_n, 1);
        chk("R3 held while disabled busy", busy, 0);
        en = 1'b1;
        @(negedge clk);
        chk("R3 fss_n low one clock after enable", fss_n, 0);
        chk("R11 busy with frame select", busy, 1);
        wait_done();
        chk("R5 tx word", last_word, 16'h00C3);
        chk("R8 fss low length", last_low, 4 * 9);
        pop_rx(w);
        chk("R7 rx word", w, 16'h00C3);
    endtask

    // Single frame under a given format.
    task automatic t_frame(input logic cp, input logic ph, input int nb,
                           input int pres, input logic [15:0] w, input logic inv);
        logic [15:0] r, mask;
        int n;
        n = clampn(nb);
        mask = (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
        cpol = cp; cpha = ph; frame_bits = 5'(nb); prescale = 8'(pres); rx_inv = inv;
        repeat (3) @(negedge clk);
        chk("R1 sclk rests at cpol", sclk_o, int'(cp));
        push(w);
        wait_done();
        chk("R5 MSB-first tx word", last_word, int'(w & mask));
        chk("R4 capture edge count", last_edges, n);
        chk("R8 fss low length", last_low, pres * (n + 1));
        chk("R6 capture edge rx", rx_empty, 0);
        pop_rx(r);
        chk("R7 right-justified rx", r, int'((inv ? ~w : w) & mask));
        rx_inv = 1'b0;
    endtask

    // Back-to-back frames with a one-bit gap.
    task automatic t_continuous();
        logic [15:0] r;
        int f0;
        cpol = 1'b0; cpha = 1'b0; frame_bits = 5'd6; prescale = 8'd6;
        en = 1'b0;
        repeat (3) @(negedge clk);
        push(16'h0015); push(16'h002A); push(16'h0033);
        f0 = frames;
        en = 1'b1;
        @(negedge clk);
        while (fss_n) @(negedge clk);
        while (!fss_n) @(negedge clk);
        chk("R11 busy in gap", busy, 1);
        wait_done();
        chk("R9 frame count", frames - f0, 3);
        chk("R9 gap length", last_gap, 6);
        pop_rx(r); chk("R9 rx word 0", r, 16'h0015);
        pop_rx(r); chk("R9 rx word 1", r, 16'h002A);
        pop_rx(r); chk("R9 rx word 2", r, 16'h0033);
        chk("R11 busy low after burst", busy, 0);
    endtask

    // Receive queue full: later frames dropped, flag sticky.
    task automatic t_overrun();
        logic [15:0] r;
        cpol = 1'b0; cpha = 1'b1; frame_bits = 5'd4; prescale = 8'd2;
        en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 no overrun yet", overrun, 0);
        for (int i = 1; i <= 6; i++) push(16'(i));
        en = 1'b1;
        wait_done();
        chk("R10 overrun set", overrun, 1);
        for (int i = 1; i <= 4; i++) begin
            pop_rx(r);
            chk("R10 kept word", r, i);
        end
        chk("R10 dropped frames absent", rx_empty, 1);
        repeat (10) @(negedge clk);
        chk("R10 overrun sticky", overrun, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_enable_gate();
        t_frame(1'b0, 1'b0, 8, 2, 16'h009B, 1'b0);
        t_frame(1'b0, 1'b1, 12, 4, 16'h0A5E, 1'b1);
        t_frame(1'b1, 1'b0, 16, 2, 16'hC3A1, 1'b0);
        t_frame(1'b1, 1'b1, 5, 6, 16'hFF16, 1'b1);
        t_frame(1'b0, 1'b0, 2, 2, 16'h000B, 1'b0);
        t_frame(1'b0, 1'b1, 20, 2, 16'h8001, 1'b0);
        t_continuous();
        t_overrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule